// File: doc/BRIEF.md
# Set-Associative Cache Allocation Controller

This block holds the tags and replacement state of a 4-way set-associative second-level cache that sits on a shared system bus. It looks at each bus request and decides three things. It decides whether the line is present. On a miss it decides whether to claim a way and which way to claim. It then tells the data path its role: the cache drives read data, the cache absorbs write data, the cache copies the memory reply as it goes past, or memory alone handles the request. The data array, the memory controller and coherence are outside the block.

A request carries an address, a read or write direction, an L1-cacheable bit, an allocate flag and a streaming hint. The allocate flag is used only when the line is absent. A read miss that allocates claims its way at once, and the cache later keeps a copy of the memory reply. A write miss that allocates keeps the data in the cache alone, so the line becomes dirty. A line loaded with the streaming hint is evicted before any other line in its set. A dirty victim must first be handed out as a write-back request, and the request waits until that write-back is taken. A size input sets how many index bits are used, which lets the same block serve full-, half- and quarter-size arrays.

Top module: `l2_alloc_ctrl`

## Requirements
- R1: The set index is taken from address bits [10:5] when `cfg_size`=0, from bits [9:5] when it is 1, and from bits [8:5] when it is 2 or 3. The unused upper index bits are forced to zero. The tag is bits [31:9], and bits [4:0] play no part in the lookup.
- R2: An L1-cacheable request that hits gives `resp_hit`=1 and the hit way, whatever `req_alloc` says. A read hit gives `resp_supply`=1 and a write hit gives `resp_take`=1, with `resp_mem`=0 and `resp_snoop`=0 in both cases.
- R3: An L1-cacheable read miss with `req_alloc`=1 claims a way when it is accepted and gives `resp_mem`=1 and `resp_snoop`=1. A later read of the same line hits in that way.
- R4: An L1-cacheable write miss with `req_alloc`=1 claims a way and gives `resp_take`=1 and `resp_mem`=0. The line is held as dirty.
- R5: A miss with `req_alloc`=0, or any request with `req_l1c`=0, gives only `resp_mem`=1 and leaves the tags unchanged.
- R6: The victim way is chosen in this order: the lowest-numbered invalid way first, then the lowest-numbered valid way that carries the streaming mark, and otherwise the least recently used way.
- R7: Recency is updated on every hit and on every allocation. The used way becomes the most recent.
- R8: When an allocation would evict a dirty line, `req_ready` falls and `wb_valid` rises with the line address of the victim. The address is held until `wb_ready`. The victim is then invalidated and the request is accepted. A clean victim causes no stall.
- R9: The response outputs are valid on the cycle after the request is accepted (`req_valid` and `req_ready` both high). Exactly one of `resp_supply`, `resp_take` and `resp_mem` is set.
- R10: After reset every line is invalid, `req_ready`=1, `wb_valid`=0 and `resp_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_size | input | 2 | Array size: 0 full, 1 half, 2 or 3 quarter |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle |
| req_addr | input | 32 | Byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_l1c | input | 1 | Request is L1-cacheable |
| req_alloc | input | 1 | Allocate on miss |
| req_stream | input | 1 | Mark the allocated line for early eviction |
| resp_valid | output | 1 | Response outputs are valid |
| resp_hit | output | 1 | Line was present |
| resp_way | output | 2 | Way that hit or was claimed |
| resp_supply | output | 1 | Cache drives read data |
| resp_take | output | 1 | Cache absorbs write data |
| resp_snoop | output | 1 | Cache copies the memory reply |
| resp_mem | output | 1 | Memory services the request |
| wb_valid | output | 1 | Dirty victim write-back request |
| wb_ready | input | 1 | Write-back request taken |
| wb_addr | output | 32 | Line address of the victim |

## Verification
The hardest state to reach from the ports is a set in which every way is valid and dirty, with known recency, at the moment a new line needs a way. The stimulus builds this state with four allocating writes to one set. It then presents an allocating read while `wb_ready` is held low. This exposes the stall, the victim address and the release on the handshake. The streaming-first and LRU orders are reached by filling a set with reads whose recency order has been worked out step by step. The index widths are shown by resetting under each size setting and placing addresses that collide in one setting but not in another.

// File: rtl/l2a_pkg.sv
package l2a_pkg;
  localparam int ADDR_W    = 32;
  localparam int OFF_W     = 5;
  localparam int IDX_W     = 6;
  localparam int WAYS      = 4;
  localparam int WAY_W     = $clog2(WAYS);
  localparam int SETS      = 1 << IDX_W;
  localparam int CFG_STEPS = 2;
  localparam int TAG_LO    = OFF_W + IDX_W - CFG_STEPS;
  localparam int TAG_W     = ADDR_W - TAG_LO;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [IDX_W-1:0]  idx_t;
  typedef logic [TAG_W-1:0]  tag_t;
  typedef logic [WAY_W-1:0]  way_t;
  typedef logic [WAYS-1:0][WAY_W-1:0] ages_t;

  typedef struct packed {
    logic vld;
    logic drt;
    logic stm;
    tag_t tag;
  } ent_t;

  typedef enum logic {ST_RUN, ST_WB} st_t;

  // Set index under the configured size; upper index bits masked off.
  function automatic idx_t set_of(addr_t a, logic [1:0] cfg);
    idx_t m;
    m = '1;
    if (cfg != 2'd0) m[IDX_W-1] = 1'b0;
    if (cfg[1])      m[IDX_W-2] = 1'b0;
    return a[OFF_W +: IDX_W] & m;
  endfunction

  // Stored tag spans every bit above the smallest index.
  function automatic tag_t tag_of(addr_t a);
    return a[ADDR_W-1:TAG_LO];
  endfunction

  // Line address rebuilt from a stored tag and the set it sits in.
  function automatic addr_t line_of(tag_t t, idx_t s);
    return {t, s[TAG_LO-OFF_W-1:0], {OFF_W{1'b0}}};
  endfunction

  // Make way w the youngest; ways younger than it age by one.
  function automatic ages_t touch(ages_t a, way_t w);
    ages_t r;
    r = a;
    for (int i = 0; i < WAYS; i++)
      if (a[i] < a[w]) r[i] = a[i] + 1'b1;
    r[w] = '0;
    return r;
  endfunction

  function automatic ages_t ages_init();
    ages_t r;
    for (int i = 0; i < WAYS; i++) r[i] = way_t'(i);
    return r;
  endfunction

  function automatic way_t lowest(logic [WAYS-1:0] v);
    way_t r;
    r = '0;
    for (int i = WAYS-1; i >= 0; i--)
      if (v[i]) r = way_t'(i);
    return r;
  endfunction
endpackage

// File: rtl/l2a_tag_store.sv
module l2a_tag_store
  import l2a_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  idx_t              rd_set,
  output ent_t [WAYS-1:0]   rd_ents,
  output ages_t             rd_ages,
  input  logic              wr_en,
  input  idx_t              wr_set,
  input  way_t              wr_way,
  input  ent_t              wr_ent,
  input  logic              wr_touch
);
  ent_t  ents_q [SETS][WAYS];
  ages_t ages_q [SETS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        ages_q[s] <= ages_init();
        for (int w = 0; w < WAYS; w++) ents_q[s][w] <= '0;
      end
    end else if (wr_en) begin
      ents_q[wr_set][wr_way] <= wr_ent;
      if (wr_touch) ages_q[wr_set] <= touch(ages_q[wr_set], wr_way);
    end
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_rd
    assign rd_ents[w] = ents_q[rd_set][w];
  end
  assign rd_ages = ages_q[rd_set];
endmodule

// File: rtl/l2a_way_select.sv
module l2a_way_select
  import l2a_pkg::*;
(
  input  ent_t [WAYS-1:0] ents,
  input  ages_t           ages,
  input  tag_t            tag,
  output logic            hit,
  output way_t            hit_way,
  output way_t            vic_way,
  output ent_t            vic_ent
);
  logic [WAYS-1:0] match, empty, strm, oldest;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign match[w]  = ents[w].vld && (ents[w].tag == tag);
    assign empty[w]  = !ents[w].vld;
    assign strm[w]   = ents[w].vld && ents[w].stm;
    assign oldest[w] = (ages[w] == '1);
  end

  assign hit     = |match;
  assign hit_way = lowest(match);

  always_comb begin
    if (|empty)     vic_way = lowest(empty);
    else if (|strm) vic_way = lowest(strm);
    else            vic_way = lowest(oldest);
  end

  assign vic_ent = ents[vic_way];
endmodule

// File: rtl/l2_alloc_ctrl.sv
module l2_alloc_ctrl
  import l2a_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  cfg_size,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_addr,
  input  logic        req_write,
  input  logic        req_l1c,
  input  logic        req_alloc,
  input  logic        req_stream,
  output logic        resp_valid,
  output logic        resp_hit,
  output logic [1:0]  resp_way,
  output logic        resp_supply,
  output logic        resp_take,
  output logic        resp_snoop,
  output logic        resp_mem,
  output logic        wb_valid,
  input  logic        wb_ready,
  output logic [31:0] wb_addr
);
  st_t             st_q;
  idx_t            lk_set, wb_set_q;
  tag_t            lk_tag;
  way_t            hit_way, vic_way, wb_way_q;
  ent_t            vic_ent, wr_ent;
  ent_t [WAYS-1:0] rd_ents;
  ages_t           rd_ages;
  addr_t           wb_addr_q;
  logic            hit_any, wr_en, wr_touch;
  idx_t            wr_set;
  way_t            wr_way;

  // Named events for the checker.
  logic ev_hit, ev_miss_alloc, ev_need_wb, ev_accept, ev_wb_done;

  assign lk_set = set_of(req_addr, cfg_size);
  assign lk_tag = tag_of(req_addr);

  l2a_tag_store u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_set   (lk_set),
    .rd_ents  (rd_ents),
    .rd_ages  (rd_ages),
    .wr_en    (wr_en),
    .wr_set   (wr_set),
    .wr_way   (wr_way),
    .wr_ent   (wr_ent),
    .wr_touch (wr_touch)
  );

  l2a_way_select u_sel (
    .ents    (rd_ents),
    .ages    (rd_ages),
    .tag     (lk_tag),
    .hit     (hit_any),
    .hit_way (hit_way),
    .vic_way (vic_way),
    .vic_ent (vic_ent)
  );

  assign ev_hit        = req_valid && req_l1c && hit_any;
  assign ev_miss_alloc = req_valid && req_l1c && !hit_any && req_alloc;
  assign ev_need_wb    = (st_q == ST_RUN) && ev_miss_alloc && vic_ent.vld && vic_ent.drt;
  assign req_ready     = (st_q == ST_RUN) && !ev_need_wb;
  assign ev_accept     = req_valid && req_ready;
  assign ev_wb_done    = (st_q == ST_WB) && wb_ready;

  // Tag write port: eviction after write-back, or hit/allocate update.
  always_comb begin
    wr_en    = 1'b0;
    wr_set   = lk_set;
    wr_way   = vic_way;
    wr_ent   = '0;
    wr_touch = 1'b0;
    if (ev_wb_done) begin
      wr_en  = 1'b1;
      wr_set = wb_set_q;
      wr_way = wb_way_q;
    end else if (ev_accept && ev_hit) begin
      wr_en    = 1'b1;
      wr_way   = hit_way;
      wr_ent   = rd_ents[hit_way];
      wr_ent.drt = rd_ents[hit_way].drt | req_write;
      wr_touch = 1'b1;
    end else if (ev_accept && ev_miss_alloc) begin
      wr_en    = 1'b1;
      wr_ent   = '{vld: 1'b1, drt: req_write, stm: req_stream, tag: lk_tag};
      wr_touch = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_RUN;
      wb_set_q  <= '0;
      wb_way_q  <= '0;
      wb_addr_q <= '0;
    end else if (st_q == ST_RUN) begin
      if (ev_need_wb) begin
        st_q      <= ST_WB;
        wb_set_q  <= lk_set;
        wb_way_q  <= vic_way;
        wb_addr_q <= line_of(vic_ent.tag, lk_set);
      end
    end else if (ev_wb_done) begin
      st_q <= ST_RUN;
    end
  end

  assign wb_valid = (st_q == ST_WB);
  assign wb_addr  = wb_addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid  <= 1'b0;
      resp_hit    <= 1'b0;
      resp_way    <= '0;
      resp_supply <= 1'b0;
      resp_take   <= 1'b0;
      resp_snoop  <= 1'b0;
      resp_mem    <= 1'b0;
    end else begin
      resp_valid  <= ev_accept;
      resp_hit    <= ev_accept && ev_hit;
      resp_way    <= ev_hit ? hit_way : vic_way;
      resp_supply <= ev_accept && ev_hit && !req_write;
      resp_take   <= ev_accept && req_write && (ev_hit || ev_miss_alloc);
      resp_snoop  <= ev_accept && ev_miss_alloc && !req_write;
      resp_mem    <= ev_accept && !ev_hit && !(ev_miss_alloc && req_write);
    end
  end
endmodule

// File: rtl/l2_alloc_chk.sv
module l2_alloc_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        wb_valid,
  input logic        wb_ready,
  input logic [31:0] wb_addr,
  input logic        resp_valid,
  input logic        resp_hit,
  input logic        resp_supply,
  input logic        resp_take,
  input logic        resp_snoop,
  input logic        resp_mem,
  input logic        ev_accept
);
  a_r8_wb_hold: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid && !wb_ready |=> wb_valid && $stable(wb_addr));

  a_r8_stall: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> !req_ready);

  a_r9_resp_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |=> resp_valid);

  a_r9_no_resp_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_accept |=> !resp_valid);

  a_r9_one_path: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> $countones({resp_supply, resp_take, resp_mem}) == 1);

  a_r2_hit_no_mem: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && resp_hit |-> !resp_mem && !resp_snoop);

  a_r3_snoop_needs_mem: assert property (@(posedge clk) disable iff (!rst_n)
    resp_snoop |-> resp_mem && !resp_hit);

  always @(posedge clk)
    if (!rst_n) a_r10_quiet_in_reset: assert (!wb_valid && !resp_valid);

  logic unused_ok;
  assign unused_ok = req_valid;
endmodule

bind l2_alloc_ctrl l2_alloc_chk u_chk (.*);

// File: tb/l2_alloc_ctrl_tb.sv
module l2_alloc_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cfg_size = 2'd0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_l1c = 1'b0;
  logic        req_alloc = 1'b0, req_stream = 1'b0, wb_ready = 1'b0;
  logic [31:0] req_addr = '0;
  logic        req_ready, resp_valid, resp_hit, resp_supply, resp_take;
  logic        resp_snoop, resp_mem, wb_valid;
  logic [1:0]  resp_way;
  logic [31:0] wb_addr;

  int total = 0;
  int fails = 0;

  always #10 clk = ~clk;

  l2_alloc_ctrl u_dut (.*);

  typedef struct packed {
    logic wr; logic l1c; logic al; logic st; logic [31:0] addr;
    logic hit; logic [1:0] way; logic sup; logic tak; logic snp; logic mem;
  } vec_t;

  // Set 1 is filled and churned by reads (R3, R5, R6, R7); set 2 by writes (R2, R4).
  localparam int NV = 20;
  localparam vec_t TBL [NV] = '{
    '{1'b0,1'b1,1'b1,1'b0,32'h0020, 1'b0,2'd0,1'b0,1'b0,1'b1,1'b1},
    '{1'b0,1'b1,1'b0,1'b0,32'h0020, 1'b1,2'd0,1'b1,1'b0,1'b0,1'b0},
    '{1'b0,1'b1,1'b0,1'b0,32'h0820, 1'b0,2'd0,1'b0,1'b0,1'b0,1'b1},
    '{1'b0,1'b1,1'b1,1'b0,32'h0820, 1'b0,2'd1,1'b0,1'b0,1'b1,1'b1},
    '{1'b0,1'b1,1'b1,1'b0,32'h0820, 1'b1,2'd1,1'b1,1'b0,1'b0,1'b0},
    '{1'b0,1'b0,1'b1,1'b0,32'h1020, 1'b0,2'd0,1'b0,1'b0,1'b0,1'b1},
    '{1'b0,1'b1,1'b1,1'b0,32'h1020, 1'b0,2'd2,1'b0,1'b0,1'b1,1'b1},
    '{1'b0,1'b1,1'b1,1'b1,32'h1820, 1'b0,2'd3,1'b0,1'b0,1'b1,1'b1},
    '{1'b0,1'b1,1'b1,1'b0,32'h2020, 1'b0,2'd3,1'b0,1'b0,1'b1,1'b1},
    '{1'b0,1'b1,1'b0,1'b0,32'h1820, 1'b0,2'd0,1'b0,1'b0,1'b0,1'b1},
    '{1'b0,1'b1,1'b0,1'b0,32'h0020, 1'b1,2'd0,1'b1,1'b0,1'b0,1'b0},
    '{1'b0,1'b1,1'b1,1'b0,32'h2820, 1'b0,2'd1,1'b0,1'b0,1'b1,1'b1},
    '{1'b0,1'b1,1'b0,1'b0,32'h0820, 1'b0,2'd0,1'b0,1'b0,1'b0,1'b1},
    '{1'b0,1'b1,1'b0,1'b0,32'h2020, 1'b1,2'd3,1'b1,1'b0,1'b0,1'b0},
    '{1'b1,1'b1,1'b1,1'b0,32'h0040, 1'b0,2'd0,1'b0,1'b1,1'b0,1'b0},
    '{1'b1,1'b1,1'b0,1'b0,32'h0040, 1'b1,2'd0,1'b0,1'b1,1'b0,1'b0},
    '{1'b0,1'b1,1'b0,1'b0,32'h0040, 1'b1,2'd0,1'b1,1'b0,1'b0,1'b0},
    '{1'b1,1'b1,1'b0,1'b0,32'h0840, 1'b0,2'd0,1'b0,1'b0,1'b0,1'b1},
    '{1'b0,1'b1,1'b0,1'b0,32'h0840, 1'b0,2'd0,1'b0,1'b0,1'b0,1'b1},
    '{1'b0,1'b1,1'b0,1'b0,32'h005F, 1'b1,2'd0,1'b1,1'b0,1'b0,1'b0}
  };

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic string tag_for(vec_t e);
    if (e.hit) return "R2";
    if (e.snp) return "R3";
    if (e.tak) return "R4";
    return "R5";
  endfunction

  // Presents one request; response sampled at the negedge after the accepting edge.
  task automatic do_req(input vec_t e, input string req);
    logic [6:0] act, exp;
    @(negedge clk);
    req_valid = 1'b1; req_write = e.wr; req_l1c = e.l1c;
    req_alloc = e.al; req_stream = e.st; req_addr = e.addr;
    #1;
    check(req_ready === 1'b1, "R8 no stall on clean victim", 64'(req_ready), 64'd1);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    act = {resp_hit, resp_supply, resp_take, resp_snoop, resp_mem, resp_valid, 1'b0};
    exp = {e.hit, e.sup, e.tak, e.snp, e.mem, 1'b1, 1'b0};
    if (e.hit || e.snp || e.tak) begin
      act[0] = (resp_way == e.way);
      exp[0] = 1'b1;
    end
    check(act === exp, {req, " R6 R7 R9 way/outcome"}, 64'({act, resp_way}), 64'({exp, e.way}));
  endtask

  function automatic vec_t mk(logic wr, logic al, logic [31:0] a, logic hit, logic [1:0] way,
                              logic sup, logic tak, logic snp, logic mem);
    return '{wr, 1'b1, al, 1'b0, a, hit, way, sup, tak, snp, mem};
  endfunction

  task automatic do_reset(input logic [1:0] cfg);
    @(negedge clk);
    rst_n = 1'b0; cfg_size = cfg;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    do_reset(2'd0);
    #1;
    check(req_ready === 1'b1, "R10 ready after reset", 64'(req_ready), 64'd1);
    check(wb_valid === 1'b0, "R10 no write-back after reset", 64'(wb_valid), 64'd0);
    check(resp_valid === 1'b0, "R10 no response after reset", 64'(resp_valid), 64'd0);

    for (int i = 0; i < NV; i++) do_req(TBL[i], tag_for(TBL[i]));

    // R8: fill set 3 with dirty lines (R4), then force a dirty eviction of way 0.
    for (int k = 0; k < 4; k++)
      do_req(mk(1'b1, 1'b1, 32'h0060 + 32'(k) * 32'h800, 1'b0, 2'(k), 1'b0, 1'b1, 1'b0, 1'b0), "R4");
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_l1c = 1'b1; req_alloc = 1'b1;
    req_stream = 1'b0; req_addr = 32'h2060;
    #1;
    check(req_ready === 1'b0, "R8 stall on dirty victim", 64'(req_ready), 64'd0);
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      check(wb_valid === 1'b1, "R8 write-back raised", 64'(wb_valid), 64'd1);
      check(wb_addr === 32'h0060, "R8 victim address", 64'(wb_addr), 64'h60);
      check(req_ready === 1'b0, "R8 held while waiting", 64'(req_ready), 64'd0);
    end
    wb_ready = 1'b1;
    @(negedge clk);
    wb_ready = 1'b0;
    #1;
    check(req_ready === 1'b1, "R8 released after handshake", 64'(req_ready), 64'd1);
    @(negedge clk);
    req_valid = 1'b0;
    check({resp_valid, resp_way, resp_snoop, resp_mem} === 5'b1_00_11, "R8 allocation into freed way",
          64'({resp_valid, resp_way, resp_snoop, resp_mem}), 64'b1_00_11);
    check(wb_valid === 1'b0, "R8 write-back cleared", 64'(wb_valid), 64'd0);
    do_req(mk(1'b0, 1'b0, 32'h0060, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1), "R8");
    do_req(mk(1'b0, 1'b0, 32'h0860, 1'b1, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0), "R2");

    // R10: reset drops every line.
    do_reset(2'd0);
    do_req(mk(1'b0, 1'b0, 32'h0020, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1), "R10");

    // R1: half size, 0x080 and 0x480 share a set.
    do_reset(2'd1);
    do_req(mk(1'b0, 1'b1, 32'h0080, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1), "R1");
    do_req(mk(1'b0, 1'b1, 32'h0480, 1'b0, 2'd1, 1'b0, 1'b0, 1'b1, 1'b1), "R1");
    // R1: full size, they do not.
    do_reset(2'd0);
    do_req(mk(1'b0, 1'b1, 32'h0080, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1), "R1");
    do_req(mk(1'b0, 1'b1, 32'h0480, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1), "R1");
    // R1: quarter size, five lines collide; the LRU way 0 goes (R6).
    do_reset(2'd2);
    for (int k = 0; k < 4; k++)
      do_req(mk(1'b0, 1'b1, 32'h0080 + 32'(k) * 32'h200, 1'b0, 2'(k), 1'b0, 1'b0, 1'b1, 1'b1), "R1");
    do_req(mk(1'b0, 1'b1, 32'h0880, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1), "R1");
    do_req(mk(1'b0, 1'b0, 32'h0080, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1), "R1");

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule